// File: doc/BRIEF.md
# Paged Address Relocation Unit

This block turns a 16-bit virtual byte address into an 18-bit physical address. The virtual space is split into eight pages of 8 KiB, selected by the top three address bits. Each page owns a frame base register, which gives the physical start in 64-byte units, and a descriptor. The descriptor sets how many 64-byte blocks the page holds, whether the valid region sits at the bottom or the top of the page, and what kind of access is allowed. Kernel and user accesses each see their own set of eight pages.

Every access gets one result, one cycle after it is presented: either a physical address or an abort. A control/status word turns translation on and keeps a record of the first fault. While translation is off, a fixed identity map is used, and the top virtual page is sent to the top of physical space. A second status word latches the virtual address of every instruction fetch. Software loads all of these registers through a single write port.

Top module: `vpx_xlate`

## Requirements
- R1: After reset, xl_done, xl_abort, xl_paddr, stat0 and stat2 are all zero. Translation is therefore off, and every descriptor reads as "no access".
- R2: With stat0 bit 0 clear, virtual addresses below 0xE000 produce a physical address equal to the virtual address, with the two upper bits zero.
- R3: With stat0 bit 0 clear, virtual addresses 0xE000–0xFFFF produce physical 0x3E000–0x3FFFF. No access aborts while translation is off.
- R4: xl_done is high in the cycle after acc_valid. With translation on and no fault, xl_paddr = {(frame + vaddr[12:6]) mod 4096, vaddr[5:0]}, where frame is the 12-bit base of page vaddr[15:13].
- R5: When descriptor bit 3 is clear, the region grows upward. Block vaddr[12:6] is inside only if it is less than or equal to the length field in descriptor bits 14:8.
- R6: When descriptor bit 3 is set, the region grows downward. A block is inside only if it is greater than or equal to length+1, so a length of 127 leaves no valid block.
- R7: Descriptor bits 2:1 give the permission: 00 and 10 mean no access, 01 read only, 11 read/write. A read of a read-only page succeeds. A write to a read-only page aborts.
- R8: acc_user selects the user page set (1) or the kernel set (0) for the lookup. cfg_user selects in the same way which set a descriptor or frame write (cfg_kind 1 or 0) goes to, for page cfg_page.
- R9: On the first abort, stat0 records the cause and sets one flag: bit 15 for no access, bit 14 for outside the region, bit 13 for a write to a read-only page. If several causes apply, they rank in that same order. The page goes to stat0 bits 3:1, and the mode goes to bits 6:5 (00 kernel, 11 user).
- R10: While any flag is set, later aborts leave stat0 unchanged. A stat0 write (cfg_kind 2) loads bit 0 from cfg_wdata[0] and ANDs the flags with cfg_wdata[15:13]. When no flag is left, the page and mode fields clear.
- R11: Each access with acc_fetch high loads its virtual address into stat2. This happens whether translation is on or off and whether or not the access aborts.
- R12: An aborted access returns xl_abort high and xl_paddr zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_kind | input | 2 | 0 frame base, 1 descriptor, 2 stat0, 3 ignored |
| cfg_user | input | 1 | Page set written: 1 user, 0 kernel |
| cfg_page | input | 3 | Page number written |
| cfg_wdata | input | 16 | Write data |
| acc_valid | input | 1 | Access request |
| acc_vaddr | input | 16 | Virtual byte address |
| acc_user | input | 1 | Access mode: 1 user, 0 kernel |
| acc_write | input | 1 | 1 for a write access |
| acc_fetch | input | 1 | 1 for an instruction fetch |
| xl_done | output | 1 | Result valid, one cycle after acc_valid |
| xl_paddr | output | 18 | Physical address |
| xl_abort | output | 1 | Access refused |
| stat0 | output | 16 | Enable, fault flags, fault page and mode |
| stat0 | output | 16 | Enable, fault flags, fault page and mode |
| stat2 | output | 16 | Last fetch virtual address |

## Verification
A corrupted frame or descriptor entry shows up one cycle after an access to that page, in the wrong mode set. It appears either as a shifted physical address or as an abort where none was due. A faulty fault record stays visible in stat0 until software clears it. A wrong freeze condition therefore appears on the very next aborting access after the first. Because the region test depends on the block number, the checks probe the block at each boundary and the one next to it, in both growth directions.

// File: rtl/vpx_pkg.sv
package vpx_pkg;
  parameter int VA_W  = 16;
  parameter int PG_W  = 3;
  parameter int BLK_W = 7;
  parameter int OFS_W = 6;
  parameter int PA_W  = 18;

  localparam int NPAGE   = 1 << PG_W;
  localparam int NMODE   = 2;
  localparam int FRAME_W = PA_W - OFS_W;

  // cfg_kind codes
  localparam logic [1:0] CFG_FRAME = 2'd0;
  localparam logic [1:0] CFG_DESC  = 2'd1;
  localparam logic [1:0] CFG_CTRL  = 2'd2;

  // descriptor field positions inside a write word
  localparam int PD_LEN_LO  = 8;
  localparam int PD_DIR     = 3;
  localparam int PD_PERM_LO = 1;

  // stat0 field positions
  localparam int ST_EN      = 0;
  localparam int ST_PG_LO   = 1;
  localparam int ST_MODE_LO = 5;
  localparam int ST_FLT_LO  = 13;

  typedef struct packed {
    logic [BLK_W-1:0] len;
    logic             down;
    logic [1:0]       perm;
  } pdesc_t;

  typedef enum logic [1:0] {FLT_NONE, FLT_NOACC, FLT_REGION, FLT_RDONLY} fault_e;

  function automatic logic blk_inside(pdesc_t d, logic [BLK_W-1:0] b);
    return d.down ? (b > d.len) : (b <= d.len);
  endfunction

  function automatic logic [PA_W-1:0] relocate(logic [FRAME_W-1:0] base,
                                               logic [VA_W-1:0] va);
    logic [FRAME_W-1:0] f;
    f = base + FRAME_W'(va[OFS_W+BLK_W-1:OFS_W]);
    return {f, va[OFS_W-1:0]};
  endfunction

  function automatic logic [PA_W-1:0] identity_map(logic [VA_W-1:0] va);
    if (&va[VA_W-1:VA_W-PG_W])
      return {{(PA_W-VA_W){1'b1}}, va};
    return {{(PA_W-VA_W){1'b0}}, va};
  endfunction
endpackage

// File: rtl/vpx_page_regs.sv
module vpx_page_regs
  import vpx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_frame,
  input  logic               wr_desc,
  input  logic               wr_user,
  input  logic [PG_W-1:0]    wr_page,
  input  logic [VA_W-1:0]    wr_data,
  input  logic               rd_user,
  input  logic [PG_W-1:0]    rd_page,
  output logic [FRAME_W-1:0] rd_frame,
  output pdesc_t             rd_desc
);
  localparam int NENT = NMODE * NPAGE;

  logic [FRAME_W-1:0] frame_q [NMODE][NPAGE];
  pdesc_t             desc_q  [NMODE][NPAGE];
  logic [NENT-1:0]    sel_v;
  pdesc_t             desc_in;
  logic               unused_bits;

  assign desc_in.len  = wr_data[PD_LEN_LO +: BLK_W];
  assign desc_in.down = wr_data[PD_DIR];
  assign desc_in.perm = wr_data[PD_PERM_LO +: 2];
  assign unused_bits  = ^{wr_data[VA_W-1:PD_LEN_LO+BLK_W],
                          wr_data[PD_LEN_LO-1:PD_DIR+1], wr_data[0]};

  genvar m, p;
  generate
    for (m = 0; m < NMODE; m++) begin : g_mode
      for (p = 0; p < NPAGE; p++) begin : g_page
        assign sel_v[m*NPAGE+p] = (wr_user == m[0]) && (wr_page == p[PG_W-1:0]);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    for (int i = 0; i < NMODE; i++) begin
      for (int j = 0; j < NPAGE; j++) begin
        if (!rst_n) begin
          frame_q[i][j] <= '0;
          desc_q[i][j]  <= '0;
        end else if (sel_v[i*NPAGE+j]) begin
          if (wr_frame) frame_q[i][j] <= wr_data[FRAME_W-1:0];
          if (wr_desc)  desc_q[i][j]  <= desc_in;
        end
      end
    end
  end

  assign rd_frame = frame_q[rd_user][rd_page];
  assign rd_desc  = desc_q[rd_user][rd_page];
endmodule

// File: rtl/vpx_perm_check.sv
module vpx_perm_check
  import vpx_pkg::*;
(
  input  pdesc_t           desc,
  input  logic [BLK_W-1:0] blk,
  input  logic             is_write,
  output fault_e           fault
);
  logic no_access, read_only, in_region;

  assign no_access = !desc.perm[0];
  assign read_only = !desc.perm[1];
  assign in_region = blk_inside(desc, blk);

  always_comb begin
    if (no_access)              fault = FLT_NOACC;
    else if (!in_region)        fault = FLT_REGION;
    else if (is_write && read_only) fault = FLT_RDONLY;
    else                        fault = FLT_NONE;
  end
endmodule

// File: rtl/vpx_status.sv
module vpx_status
  import vpx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctrl_wr,
  input  logic [VA_W-1:0] ctrl_data,
  input  logic            abort_evt,
  input  fault_e          abort_kind,
  input  logic [PG_W-1:0] abort_page,
  input  logic            abort_user,
  input  logic            fetch_evt,
  input  logic [VA_W-1:0] fetch_va,
  output logic            xlate_on,
  output logic [VA_W-1:0] stat0,
  output logic [VA_W-1:0] stat2
);
  logic [2:0]      flags_q, flags_kept, flag_set;
  logic [PG_W-1:0] page_q;
  logic [1:0]      mode_q;
  logic            en_q;
  logic            unused_bits;

  assign flags_kept  = flags_q & ctrl_data[ST_FLT_LO +: 3];
  assign unused_bits = ^ctrl_data[ST_FLT_LO-1:ST_EN+1];

  always_comb begin
    case (abort_kind)
      FLT_NOACC:  flag_set = 3'b100;
      FLT_REGION: flag_set = 3'b010;
      FLT_RDONLY: flag_set = 3'b001;
      default:    flag_set = 3'b000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      page_q  <= '0;
      mode_q  <= '0;
      en_q    <= 1'b0;
      stat2   <= '0;
    end else begin
      if (ctrl_wr) begin
        en_q    <= ctrl_data[ST_EN];
        flags_q <= flags_kept;
        if (flags_kept == 3'b000) begin
          page_q <= '0;
          mode_q <= '0;
        end
      end else if (abort_evt && flags_q == 3'b000) begin
        flags_q <= flag_set;
        page_q  <= abort_page;
        mode_q  <= {2{abort_user}};
      end
      if (fetch_evt) stat2 <= fetch_va;
    end
  end

  always_comb begin
    stat0 = '0;
    stat0[ST_EN]               = en_q;
    stat0[ST_PG_LO +: PG_W]    = page_q;
    stat0[ST_MODE_LO +: 2]     = mode_q;
    stat0[ST_FLT_LO +: 3]      = flags_q;
  end
  assign xlate_on = en_q;

  AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flags_q)); // R9
  AST_RECORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q != 3'b000 && !ctrl_wr) |=> $stable(flags_q) && $stable(page_q) && $stable(mode_q)); // R10
  AST_FETCH_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_evt |=> stat2 == $past(fetch_va)); // R11
endmodule

// File: rtl/vpx_xlate.sv
module vpx_xlate
  import vpx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_kind,
  input  logic        cfg_user,
  input  logic [2:0]  cfg_page,
  input  logic [15:0] cfg_wdata,
  input  logic        acc_valid,
  input  logic [15:0] acc_vaddr,
  input  logic        acc_user,
  input  logic        acc_write,
  input  logic        acc_fetch,
  output logic        xl_done,
  output logic [17:0] xl_paddr,
  output logic        xl_abort,
  output logic [15:0] stat0,
  output logic [15:0] stat2
);
  logic [PG_W-1:0]    acc_page;
  logic [BLK_W-1:0]   acc_blk;
  logic [FRAME_W-1:0] sel_frame;
  pdesc_t             sel_desc;
  fault_e             fault;
  logic               xlate_on;
  logic               abort_nx;
  logic [PA_W-1:0]    paddr_nx;

  assign acc_page = acc_vaddr[VA_W-1 -: PG_W];
  assign acc_blk  = acc_vaddr[OFS_W +: BLK_W];

  vpx_page_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_frame (cfg_we && cfg_kind == CFG_FRAME),
    .wr_desc  (cfg_we && cfg_kind == CFG_DESC),
    .wr_user  (cfg_user),
    .wr_page  (cfg_page),
    .wr_data  (cfg_wdata),
    .rd_user  (acc_user),
    .rd_page  (acc_page),
    .rd_frame (sel_frame),
    .rd_desc  (sel_desc)
  );

  vpx_perm_check u_check (
    .desc     (sel_desc),
    .blk      (acc_blk),
    .is_write (acc_write),
    .fault    (fault)
  );

  vpx_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (cfg_we && cfg_kind == CFG_CTRL),
    .ctrl_data  (cfg_wdata),
    .abort_evt  (acc_valid && abort_nx),
    .abort_kind (fault),
    .abort_page (acc_page),
    .abort_user (acc_user),
    .fetch_evt  (acc_valid && acc_fetch),
    .fetch_va   (acc_vaddr),
    .xlate_on   (xlate_on),
    .stat0      (stat0),
    .stat2      (stat2)
  );

  assign abort_nx = xlate_on && (fault != FLT_NONE);

  always_comb begin
    if (!xlate_on)     paddr_nx = identity_map(acc_vaddr);
    else if (abort_nx) paddr_nx = '0;
    else               paddr_nx = relocate(sel_frame, acc_vaddr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xl_done  <= 1'b0;
      xl_abort <= 1'b0;
      xl_paddr <= '0;
    end else begin
      xl_done  <= acc_valid;
      xl_abort <= acc_valid && abort_nx;
      if (acc_valid) xl_paddr <= paddr_nx;
    end
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> xl_done); // R4
  AST_OFF_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !xlate_on) |=> !xl_abort && xl_paddr[VA_W-1:0] == $past(acc_vaddr)); // R3
  AST_RO_READ_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write) |-> fault != FLT_RDONLY); // R7
  AST_ABORT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    xl_abort |-> xl_paddr == '0); // R12
endmodule

// File: tb/vpx_xlate_test.sv
`timescale 1ns/1ps
module vpx_xlate_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, cfg_we, cfg_user, acc_valid, acc_user, acc_write, acc_fetch;
  logic [1:0]  cfg_kind;
  logic [2:0]  cfg_page;
  logic [15:0] cfg_wdata, acc_vaddr, stat0, stat2;
  logic        xl_done, xl_abort;
  logic [17:0] xl_paddr;

  vpx_xlate uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_user(cfg_user), .cfg_page(cfg_page), .cfg_wdata(cfg_wdata),
    .acc_valid(acc_valid), .acc_vaddr(acc_vaddr), .acc_user(acc_user),
    .acc_write(acc_write), .acc_fetch(acc_fetch), .xl_done(xl_done),
    .xl_paddr(xl_paddr), .xl_abort(xl_abort), .stat0(stat0), .stat2(stat2)
  );

  int n_vec = 0, n_bad = 0;
  logic [18:0] exp_q[$];
  string       tag_q[$];

  logic [11:0] m_frame [2][8];
  logic [6:0]  m_len   [2][8];
  logic        m_down  [2][8];
  logic [1:0]  m_perm  [2][8];
  logic [15:0] m_s0, m_s2;

  task automatic note(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // 0 none, 1 no access, 2 outside region, 3 write to read-only
  function automatic int b_fault(input bit usr, input logic [15:0] va, input bit wr);
    int pg, blk;
    bit ok_reg;
    pg  = int'(va >> 13);
    blk = int'((va >> 6) & 16'h7F);
    if (m_perm[usr][pg] == 2'b00 || m_perm[usr][pg] == 2'b10) return 1;
    ok_reg = m_down[usr][pg] ? (blk > int'(m_len[usr][pg])) : (blk <= int'(m_len[usr][pg]));
    if (!ok_reg) return 2;
    if (wr && m_perm[usr][pg] == 2'b01) return 3;
    return 0;
  endfunction

  task automatic access(input logic [15:0] va, input bit usr, input bit wr, input bit fet, input string tag);
    logic [17:0] ep;
    logic [11:0] fr;
    bit ea;
    int f;
    ea = 1'b0;
    if (m_s0[0]) begin
      f = b_fault(usr, va, wr);
      ea = (f != 0);
      fr = m_frame[usr][va[15:13]] + 12'(va[12:6]);
      ep = ea ? 18'h0 : {fr, va[5:0]};
      if (ea && m_s0[15:13] == 3'b000)
        m_s0 = {(f == 1) ? 3'b100 : (f == 2) ? 3'b010 : 3'b001, 6'b0,
                usr ? 2'b11 : 2'b00, 1'b0, va[15:13], m_s0[0]};
    end else begin
      ep = (va >= 16'hE000) ? 18'(va) + 18'h30000 : 18'(va);
    end
    if (fet) m_s2 = va;
    exp_q.push_back({ea, ep});
    tag_q.push_back(tag);
    acc_valid = 1'b1; acc_vaddr = va; acc_user = usr; acc_write = wr; acc_fetch = fet;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0; acc_fetch = 1'b0;
  endtask

  task automatic cfg(input logic [1:0] kind, input bit usr, input logic [2:0] pg, input logic [15:0] wd);
    logic [2:0] nf;
    case (kind)
      2'd0: m_frame[usr][pg] = wd[11:0];
      2'd1: begin m_len[usr][pg] = wd[14:8]; m_down[usr][pg] = wd[3]; m_perm[usr][pg] = wd[2:1]; end
      2'd2: begin
        nf = m_s0[15:13] & wd[15:13];
        m_s0 = {nf, 6'b0, (nf == 3'b000) ? 2'b00 : m_s0[6:5], 1'b0,
                (nf == 3'b000) ? 3'b000 : m_s0[3:1], wd[0]};
      end
      default: ;
    endcase
    cfg_we = 1'b1; cfg_kind = kind; cfg_user = usr; cfg_page = pg; cfg_wdata = wd;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic check_stat(input string tag);
    note(stat0 == m_s0, {tag, " stat0"}, 32'(stat0), 32'(m_s0));
    note(stat2 == m_s2, {tag, " stat2"}, 32'(stat2), 32'(m_s2));
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && xl_done) begin
      if (exp_q.size() == 0) begin
        note(1'b0, "R4 unexpected result", 32'({xl_abort, xl_paddr}), 32'h0);
      end else begin
        logic [18:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        note({xl_abort, xl_paddr} == e, t, 32'({xl_abort, xl_paddr}), 32'(e));
      end
    end
  end

  initial begin
    #(8 * 100000);
    note(1'b0, "watchdog expired", 32'h0, 32'h1);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_kind = 2'd0; cfg_user = 1'b0; cfg_page = 3'd0;
    cfg_wdata = 16'h0; acc_valid = 1'b0; acc_vaddr = 16'h0; acc_user = 1'b0;
    acc_write = 1'b0; acc_fetch = 1'b0;
    for (int i = 0; i < 2; i++)
      for (int j = 0; j < 8; j++) begin
        m_frame[i][j] = '0; m_len[i][j] = '0; m_down[i][j] = 1'b0; m_perm[i][j] = 2'b00;
      end
    m_s0 = 16'h0; m_s2 = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    note(xl_done == 1'b0 && xl_abort == 1'b0, "R1 reset flags", 32'({xl_done, xl_abort}), 32'h0);
    note(xl_paddr == 18'h0, "R1 reset paddr", 32'(xl_paddr), 32'h0);
    check_stat("R1 reset");

    // R2 / R3 identity map, translation off
    access(16'h1234, 1'b0, 1'b0, 1'b0, "R2 low identity");
    access(16'hDFFF, 1'b1, 1'b1, 1'b0, "R2 page6 top identity");
    access(16'hE000, 1'b0, 1'b1, 1'b0, "R3 top page base");
    access(16'hFFFF, 1'b1, 1'b0, 1'b1, "R3 top page end");
    check_stat("R11 fetch while off");

    // program page registers
    cfg(2'd0, 1'b0, 3'd1, 16'h0800);
    cfg(2'd1, 1'b0, 3'd1, 16'h0A06);   // len 10, up, read/write
    cfg(2'd0, 1'b0, 3'd2, 16'h0FFF);
    cfg(2'd1, 1'b0, 3'd2, 16'h630A);   // len 99, down, read only
    cfg(2'd0, 1'b1, 3'd1, 16'h0100);
    cfg(2'd1, 1'b1, 3'd1, 16'h7F06);   // len 127, up, read/write
    cfg(2'd1, 1'b1, 3'd3, 16'h7F0E);   // len 127, down, read/write: nothing valid
    cfg(2'd2, 1'b0, 3'd0, 16'h0001);   // enable
    check_stat("R10 enable write");

    // R5 upward region
    access(16'h2005, 1'b0, 1'b1, 1'b0, "R5 up blk0");
    access(16'h2285, 1'b0, 1'b0, 1'b0, "R5 up blk10 edge");
    access(16'h22C0, 1'b0, 1'b0, 1'b0, "R5 up blk11 abort R12");
    check_stat("R9 region record");
    access(16'h0010, 1'b0, 1'b0, 1'b0, "R9 no-access kernel p0");
    check_stat("R10 record frozen");
    cfg(2'd2, 1'b0, 3'd0, 16'h0001);
    check_stat("R10 cleared");

    // R6 downward region, R7 read-only
    access(16'h5900, 1'b0, 1'b0, 1'b0, "R6 down blk100 wrap");
    access(16'h58C0, 1'b0, 1'b0, 1'b0, "R6 down blk99 abort");
    cfg(2'd2, 1'b0, 3'd0, 16'h0001);
    access(16'h5E00, 1'b0, 1'b0, 1'b0, "R7 read-only read ok");
    access(16'h5E00, 1'b0, 1'b1, 1'b0, "R7 read-only write abort");
    check_stat("R7 rdonly flag");
    cfg(2'd2, 1'b0, 3'd0, 16'h8001);   // flags not kept by this mask
    check_stat("R10 partial mask clears");

    // R8 separate sets
    access(16'h3FC1, 1'b1, 1'b1, 1'b0, "R8 user p1 blk127");
    access(16'h2281, 1'b1, 1'b0, 1'b0, "R8 user p1 blk10");
    access(16'h2281, 1'b0, 1'b0, 1'b0, "R8 kernel p1 blk10");
    access(16'h6000, 1'b1, 1'b0, 1'b1, "R6 down len127 none valid");
    check_stat("R9 user region record + R11");
    cfg(2'd2, 1'b0, 3'd0, 16'h0001);
    access(16'h4140, 1'b1, 1'b0, 1'b0, "R9 user p2 no-access priority");
    check_stat("R9 noacc user record");
    cfg(2'd2, 1'b0, 3'd0, 16'h0001);
    access(16'h2300, 1'b0, 1'b1, 1'b1, "R11 aborted fetch");
    check_stat("R11 fetch on abort");
    cfg(2'd3, 1'b0, 3'd1, 16'hFFFF);   // kind 3 ignored
    access(16'h2285, 1'b0, 1'b0, 1'b0, "R8 kind3 no effect");

    // R3 disable again: no aborts, identity map
    cfg(2'd2, 1'b0, 3'd0, 16'h0000);
    access(16'h4140, 1'b1, 1'b1, 1'b0, "R3 off no abort");
    access(16'hF0F0, 1'b0, 1'b0, 1'b0, "R3 off top page");
    check_stat("R3 off status");

    repeat (3) @(negedge clk);
    note(exp_q.size() == 0, "R4 results pending", 32'(exp_q.size()), 32'h0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule